// File: doc/BRIEF.md
# Host Command Decoder with Refresh Timer

This block is the host-facing front end of an SDRAM controller. On every rising clock edge it samples a 3-bit command code and an address word from the host. A command that starts in that cycle is turned into a one-cycle request strobe for the downstream command sequencer, and the address is captured with it. Two codes never leave the block. One loads a timing and mode configuration word from the low address bits. The other loads a 16-bit refresh interval.

A programmable down counter produces periodic refresh requests. It starts from the interval register and decrements once per clock. When it reaches zero it raises a refresh request and holds it until the sequencer acknowledges it, then reloads and starts again. When the configuration selects full-page operation, automatic refresh is turned off and the host issues refreshes itself.

Top module: `hcd_front`

## Requirements
- R1: After reset all request strobes and the refresh request are 0, the captured address is 0, the configuration word is 0x107B (CAS 3, RAS-to-CAS 2, refresh duration 7, page mode off, burst 8) and the interval register holds 1562.
- R2: Command codes 001 read, 010 write, 011 refresh, 100 precharge-all and 101 load-mode-register each raise their own strobe (req_read, req_write, req_refresh, req_precharge, req_mode) in the cycle after the sampling edge. Code 000 raises none.
- R3: A strobe fires only on the edge where the sampled code differs from the code sampled on the previous edge. A code held for several cycles gives exactly one pulse, and changing directly from one code to another gives a pulse for the new code.
- R4: req_addr takes the host address on the edge that raises a strobe. It stays unchanged across NOP, held codes and both register-load codes.
- R5: Code 110 loads the configuration from the address: bits [1:0] CAS latency, [3:2] RAS-to-CAS delay, [7:4] refresh duration, [8] page mode (1 = full page), [12:9] burst length. It raises no strobe.
- R6: Code 111 loads the interval register from address bits [15:0] and raises no strobe. On the same edge it reloads the refresh counter with the new value, whether the counter is mid-count or a request is pending.
- R7: With page mode off, the counter decrements once per clock from the loaded value P. The refresh request rises on the edge after the count reaches zero, so the request appears P+1 cycles after the load.
- R8: A raised refresh request stays high until rfsh_ack is sampled high. That edge clears it and reloads the counter from the interval register. rfsh_ack has no effect while no request is pending.
- R9: While page mode is set, the refresh request is forced low (a pending one is dropped) and the counter stays at the interval value. The host refresh code still raises req_refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_cmd | input | 3 | Host command code |
| host_addr | input | AW (24) | Host address / register load value |
| rfsh_ack | input | 1 | Sequencer acknowledge of the refresh request |
| req_read | output | 1 | Read with auto-precharge strobe |
| req_write | output | 1 | Write with auto-precharge strobe |
| req_refresh | output | 1 | Host refresh strobe |
| req_precharge | output | 1 | Precharge-all strobe |
| req_mode | output | 1 | Load-mode-register strobe |
| req_addr | output | AW (24) | Address captured with the strobe |
| cfg_cas | output | 2 | CAS latency field |
| cfg_rcd | output | 2 | RAS-to-CAS delay field |
| cfg_rdur | output | 4 | Refresh duration field |
| cfg_page | output | 1 | Full-page mode flag |
| cfg_blen | output | 4 | Burst length field |
| cfg_period | output | PW (16) | Refresh interval register |
| rfsh_req | output | 1 | Periodic refresh request |

## Verification
The hardest cases to reach from the ports involve events that land on top of a pending refresh. These are an interval reload while the request waits for its acknowledge, and a switch into page mode that must drop a request already raised. The stimulus loads short intervals so the counter expires within a few dozen cycles. It withholds the acknowledge to keep a request pending, then issues the interval load or the page-mode configuration load at that point. A behavioural model in the bench follows every edge, so any mismatch in the reload value or in the timing of the next request shows up at once.

// File: rtl/hcd_pkg.sv
package hcd_pkg;

   typedef enum logic [2:0] {
      HC_IDLE   = 3'd0,
      HC_RDAP   = 3'd1,
      HC_WRAP   = 3'd2,
      HC_RFSH   = 3'd3,
      HC_PCALL  = 3'd4,
      HC_LDMODE = 3'd5,
      HC_LDCFG  = 3'd6,
      HC_LDPER  = 3'd7
   } host_cmd_e;

   // number of codes forwarded as strobes (codes 1..NUM_FWD)
   localparam int NUM_FWD = 5;
   localparam int CFG_W   = 13;

   // packed so that the field positions match the address bits
   typedef struct packed {
      logic [3:0] blen;   // [12:9]
      logic       pmode;  // [8]
      logic [3:0] rdur;   // [7:4]
      logic [1:0] trcd;   // [3:2]
      logic [1:0] cas;    // [1:0]
   } cfg1_t;

endpackage

// File: rtl/hcd_decode.sv
module hcd_decode
   import hcd_pkg::*;
#(
   parameter int AW = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2:0]         cmd,
   input  logic [AW-1:0]      addr,
   output logic [NUM_FWD-1:0] fwd_stb,
   output logic [AW-1:0]      fwd_addr,
   output logic               ld_cfg,
   output logic               ld_per
);

   logic [2:0] last_q;
   logic       is_new;
   logic       any_fwd;

   assign is_new = (cmd != last_q);
   assign ld_cfg = is_new && (cmd == HC_LDCFG);
   assign ld_per = is_new && (cmd == HC_LDPER);
   assign any_fwd = is_new && (cmd != HC_IDLE) && (cmd != HC_LDCFG) && (cmd != HC_LDPER);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= HC_IDLE;
      else        last_q <= cmd;
   end

   for (genvar g = 0; g < NUM_FWD; g++) begin : g_stb
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) fwd_stb[g] <= 1'b0;
         else        fwd_stb[g] <= is_new && (cmd == 3'(g + 1));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       fwd_addr <= '0;
      else if (any_fwd) fwd_addr <= addr;
   end

   // R2: never two requests at once
   a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fwd_stb));

   // R3: a strobe never repeats on the next cycle
   a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (|fwd_stb) |=> ((fwd_stb & $past(fwd_stb)) == '0));

   // R4: address moves only together with a strobe
   a_r4_addr_with_stb: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fwd_addr) |-> (|fwd_stb));

endmodule

// File: rtl/hcd_cfg.sv
module hcd_cfg
   import hcd_pkg::*;
#(
   parameter int          PW        = 16,
   parameter logic [12:0] CFG1_RST  = 13'h107B,
   parameter int          DEF_PER   = 1562
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_cfg,
   input  logic          ld_per,
   input  logic [PW-1:0] addr_lo,
   output cfg1_t         cfg1,
   output logic [PW-1:0] period
);

   localparam logic [PW-1:0] PER_RST = PW'(DEF_PER);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg1 <= cfg1_t'(CFG1_RST);
      else if (ld_cfg) cfg1 <= cfg1_t'(addr_lo[CFG_W-1:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      period <= PER_RST;
      else if (ld_per) period <= addr_lo;
   end

   // R5: configuration fields follow the address bits
   a_r5_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
      ld_cfg |=> (cfg1 == $past(addr_lo[CFG_W-1:0])));

   // R6: interval register takes the load value
   a_r6_per_load: assert property (@(posedge clk) disable iff (!rst_n)
      ld_per |=> (period == $past(addr_lo)));

endmodule

// File: rtl/hcd_rfsh.sv
module hcd_rfsh #(
   parameter int PW      = 16,
   parameter int DEF_PER = 1562
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          auto_en,
   input  logic          ld,
   input  logic [PW-1:0] ld_val,
   input  logic [PW-1:0] period,
   input  logic          ack,
   output logic          req
);

   localparam logic [PW-1:0] CNT_RST = PW'(DEF_PER);

   logic [PW-1:0] cnt_q;
   logic [PW-1:0] reload;

   assign reload = ld ? ld_val : period;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_RST;
         req   <= 1'b0;
      end else if (!auto_en) begin
         req   <= 1'b0;
         cnt_q <= reload;
      end else if (req && ack) begin
         req   <= 1'b0;
         cnt_q <= reload;
      end else if (ld) begin
         cnt_q <= ld_val;
      end else if (!req) begin
         if (cnt_q == '0) req <= 1'b1;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   // R7: request rises only out of an expired count
   a_r7_rise_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req) |-> ($past(cnt_q) == '0));

   // R8: pending request waits for the acknowledge
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !ack && auto_en) |=> req);

   a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (req && ack) |=> !req);

   // R6: a load always lands in the counter
   a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (cnt_q == $past(ld_val)));

   // R9: page mode keeps the request low
   a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_en |=> !req);

endmodule

// File: rtl/hcd_front.sv
module hcd_front
   import hcd_pkg::*;
#(
   parameter int          AW       = 24,
   parameter int          PW       = 16,
   parameter logic [12:0] CFG1_RST = 13'h107B,
   parameter int          DEF_PER  = 1562
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    host_cmd,
   input  logic [AW-1:0] host_addr,
   input  logic          rfsh_ack,
   output logic          req_read,
   output logic          req_write,
   output logic          req_refresh,
   output logic          req_precharge,
   output logic          req_mode,
   output logic [AW-1:0] req_addr,
   output logic [1:0]    cfg_cas,
   output logic [1:0]    cfg_rcd,
   output logic [3:0]    cfg_rdur,
   output logic          cfg_page,
   output logic [3:0]    cfg_blen,
   output logic [PW-1:0] cfg_period,
   output logic          rfsh_req
);

   initial begin : p_param_chk
      a_prm_pw: assert (PW >= CFG_W) else $error("PW must cover the config field");
      a_prm_aw: assert (AW >= PW) else $error("AW must cover the interval value");
      a_prm_def: assert (DEF_PER > 0 && DEF_PER < (2 ** PW)) else $error("DEF_PER out of range");
   end

   logic [NUM_FWD-1:0] stb;
   logic               ld_cfg;
   logic               ld_per;
   cfg1_t              cfg1;
   logic [PW-1:0]      addr_lo;

   assign addr_lo = host_addr[PW-1:0];

   hcd_decode #(.AW(AW)) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (host_cmd),
      .addr     (host_addr),
      .fwd_stb  (stb),
      .fwd_addr (req_addr),
      .ld_cfg   (ld_cfg),
      .ld_per   (ld_per)
   );

   hcd_cfg #(.PW(PW), .CFG1_RST(CFG1_RST), .DEF_PER(DEF_PER)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_cfg  (ld_cfg),
      .ld_per  (ld_per),
      .addr_lo (addr_lo),
      .cfg1    (cfg1),
      .period  (cfg_period)
   );

   hcd_rfsh #(.PW(PW), .DEF_PER(DEF_PER)) u_rfsh (
      .clk     (clk),
      .rst_n   (rst_n),
      .auto_en (!cfg1.pmode),
      .ld      (ld_per),
      .ld_val  (addr_lo),
      .period  (cfg_period),
      .ack     (rfsh_ack),
      .req     (rfsh_req)
   );

   assign req_read      = stb[0];
   assign req_write     = stb[1];
   assign req_refresh   = stb[2];
   assign req_precharge = stb[3];
   assign req_mode      = stb[4];

   assign cfg_cas  = cfg1.cas;
   assign cfg_rcd  = cfg1.trcd;
   assign cfg_rdur = cfg1.rdur;
   assign cfg_page = cfg1.pmode;
   assign cfg_blen = cfg1.blen;

endmodule

// File: tb/sim_hcd_front.sv
module sim_hcd_front;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 24;
   localparam int PW = 16;
   localparam int DEF_PER = 1562;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] host_cmd = '0;
   logic [AW-1:0] host_addr = '0;
   logic rfsh_ack = 1'b0;
   logic req_read, req_write, req_refresh, req_precharge, req_mode;
   logic [AW-1:0] req_addr;
   logic [1:0] cfg_cas, cfg_rcd;
   logic [3:0] cfg_rdur, cfg_blen;
   logic cfg_page;
   logic [PW-1:0] cfg_period;
   logic rfsh_req;

   always #(CLK_PERIOD/2) clk = ~clk;

   hcd_front #(.AW(AW), .PW(PW), .DEF_PER(DEF_PER)) u0 (
      .clk(clk), .rst_n(rst_n), .host_cmd(host_cmd), .host_addr(host_addr),
      .rfsh_ack(rfsh_ack), .req_read(req_read), .req_write(req_write),
      .req_refresh(req_refresh), .req_precharge(req_precharge), .req_mode(req_mode),
      .req_addr(req_addr), .cfg_cas(cfg_cas), .cfg_rcd(cfg_rcd), .cfg_rdur(cfg_rdur),
      .cfg_page(cfg_page), .cfg_blen(cfg_blen), .cfg_period(cfg_period),
      .rfsh_req(rfsh_req)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   string stag = "R2";
   string rtag = "R7";

   // behavioural reference state
   int m_last = 0;
   logic [4:0] m_stb = '0;
   logic [AW-1:0] m_addr = '0;
   logic [12:0] m_cfg = 13'h107B;
   int m_period = DEF_PER;
   int m_cnt = DEF_PER;
   bit m_req = 1'b0;

   task automatic chk(string tag, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_step(logic [2:0] c, logic [AW-1:0] a, logic k);
      int ci = int'(c);
      bit nw = (ci != m_last);
      bit ld1, ld2;
      int nv = int'(a[PW-1:0]);
      m_last = ci;
      m_stb = '0;
      if (nw && ci >= 1 && ci <= 5) begin
         m_stb[ci-1] = 1'b1;
         m_addr = a;
      end
      ld1 = nw && ci == 6;
      ld2 = nw && ci == 7;
      if (m_cfg[8]) begin
         m_req = 0;
         m_cnt = ld2 ? nv : m_period;
      end else if (m_req && k) begin
         m_req = 0;
         m_cnt = ld2 ? nv : m_period;
      end else if (ld2) begin
         m_cnt = nv;
      end else if (!m_req) begin
         if (m_cnt == 0) m_req = 1;
         else m_cnt = m_cnt - 1;
      end
      if (ld1) m_cfg = a[12:0];
      if (ld2) m_period = nv;
   endtask

   task automatic compare_all();
      chk(stag, "strobes", {req_mode, req_precharge, req_refresh, req_write, req_read}, m_stb);
      chk("R4", "req_addr", req_addr, m_addr);
      chk("R5", "cfg", {cfg_blen, cfg_page, cfg_rdur, cfg_rcd, cfg_cas}, m_cfg);
      chk("R6", "cfg_period", cfg_period, m_period);
      chk(rtag, "rfsh_req", rfsh_req, m_req);
   endtask

   task automatic cyc(logic [2:0] c, logic [AW-1:0] a, logic k);
      host_cmd = c;
      host_addr = a;
      rfsh_ack = k;
      model_step(c, a, k);
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle(int n, logic k);
      for (int i = 0; i < n; i++) cyc(3'd0, '0, k);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog all-reqs act=running exp=done");
         summary();
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "strobes", {req_mode, req_precharge, req_refresh, req_write, req_read}, 0);
      chk("R1", "rfsh_req", rfsh_req, 0);
      chk("R1", "req_addr", req_addr, 0);
      chk("R1", "cfg", {cfg_blen, cfg_page, cfg_rdur, cfg_rcd, cfg_cas}, 13'h107B);
      chk("R1", "cfg_period", cfg_period, DEF_PER);
      rst_n = 1'b1;

      // R6: short interval; R2: each code once
      stag = "R2"; rtag = "R7";
      cyc(3'd7, 24'd20, 0); idle(1, 0);
      cyc(3'd1, 24'h00A5A5, 0); idle(1, 0);
      cyc(3'd2, 24'h123456, 0); idle(1, 0);
      cyc(3'd3, 24'h0000F0, 0); idle(1, 0);
      cyc(3'd4, 24'h000400, 0); idle(1, 0);
      cyc(3'd5, 24'h000ABC, 0); idle(2, 0);

      // R3: held codes and back-to-back changes
      stag = "R3";
      for (int i = 0; i < 4; i++) cyc(3'd1, 24'h111111, 0);
      cyc(3'd2, 24'h222222, 0);
      cyc(3'd1, 24'h333333, 0);
      for (int i = 0; i < 3; i++) cyc(3'd5, 24'h444444, 0);
      idle(1, 0);

      // R5: config load, held for two cycles with a new value
      stag = "R5";
      cyc(3'd6, {11'h0, 4'd4, 1'b0, 4'd9, 2'd3, 2'd2}, 0); idle(2, 0);
      cyc(3'd6, {11'h7FF, 4'd2, 1'b0, 4'd5, 2'd1, 2'd3}, 0);
      cyc(3'd6, {11'h0, 4'd1, 1'b0, 4'd1, 2'd1, 2'd1}, 0);
      idle(1, 0);

      // R8: hold until ack, ack without request ignored
      stag = "R2"; rtag = "R8";
      idle(30, 0);
      idle(1, 1);
      idle(5, 1);
      idle(1, 0);
      idle(30, 0);
      idle(1, 1);

      // R6: reload mid count and while pending
      rtag = "R6";
      cyc(3'd7, 24'd8, 0); idle(3, 0);
      cyc(3'd7, 24'd40, 0); idle(50, 0);
      cyc(3'd7, 24'd3, 0); idle(4, 0);
      idle(1, 1);
      cyc(3'd7, 24'd0, 1); idle(3, 0);
      cyc(3'd7, 24'd6, 1); idle(12, 0);

      // R9: page mode drops the pending request
      rtag = "R9";
      cyc(3'd6, {11'h0, 4'd8, 1'b1, 4'd7, 2'd2, 2'd3}, 0);
      idle(30, 0);
      stag = "R9";
      cyc(3'd3, 24'h000077, 0);
      idle(30, 1);
      cyc(3'd6, {11'h0, 4'd8, 1'b0, 4'd7, 2'd2, 2'd3}, 0);
      idle(20, 0);

      // R7: steady operation with prompt acks
      stag = "R2"; rtag = "R7";
      cyc(3'd7, 24'd4, 0);
      idle(40, 1);

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule